// File: doc/BRIEF.md
# Address-Error Exception Frame Writer

This block assembles the long exception frame that a 16-bit-bus processor core pushes onto its supervisor stack after a bus error or an address error. It watches the data traffic of the core all the time. It keeps the word of the most recent data read, prefetch words included, and the word of the most recent data write. When the core raises a fault request, the block captures the fault attributes and the core's state. It forms a special status word, lowers the stack pointer by the size of the frame, and then writes the frame to memory one 16-bit word per handshake.

The frame is 58 bytes long. The lower 50 bytes hold the status word, the fault address, the two data buffers, the instruction word, a zero version word and zero-filled internal words. Above them sit the status register, the return PC and a format/vector word. The core waits for the done pulse and then reads the new stack pointer. Detecting odd addresses and decoding instructions are left to the core.

Top module: `fault_frame_writer`

## Requirements
- R1: Status word encoding: bit 10 is the high-byte flag, bit 9 is set for a byte-sized access, bit 8 is set for a read and clear for a write, bits 2:0 carry the function code, and all other bits are zero.
- R2: When the fault is an instruction fetch (`flt_fetch` = 1), status bit 8 is clear whatever `flt_read` says, and the output buffer is not overridden.
- R3: When `flt_zup` = 1, status bits 15:8 are written as zero, so only the function code remains.
- R4: On an accepted request, `sp_out` becomes `sp_in` − 58 in the next cycle, and the frame fills the bytes from `sp_out` up to `sp_in` − 1.
- R5: Frame word k sits at `sp_out` + 2k (big-endian, high half first). Words 0 to 8 are: status, fault address high, fault address low, 0, output buffer, 0, input buffer, 0, instruction word. Word 9 (version) and words 10 to 24 are zero. Word 25 is the status register, words 26 and 27 are the PC high and low halves, and word 28 is {4'h8, 2'b00, vector, 2'b00}.
- R6: The input-buffer word (word 6) is the data of the last `rd_stb` cycle before the request.
- R7: The output-buffer word (word 4) is the data of the last `wr_stb` cycle. For a write fault (read = 0, fetch = 0) it is `flt_wdata` instead, and that value then stays in the write latch.
- R8: Words go out in ascending address order. `mem_addr` and `mem_wdata` hold steady while `mem_wr` = 1 and `mem_rdy` = 0. Each cycle with `mem_wr` and `mem_rdy` high completes one word, and exactly 29 words are written.
- R9: `done` is high for exactly one cycle, the cycle after the last word's handshake, and `mem_wr` is low in that cycle.
- R10: A fault request raised while a frame is being written is ignored: `sp_out` does not change and the frame in progress is neither restarted nor altered.
- R11: During reset `mem_wr`, `done` and `sp_out` are zero. Both data latches clear, so a frame written before any traffic has zero buffer words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | A data read (or prefetch) completes this cycle |
| rd_data | input | 16 | Word returned by that read |
| wr_stb | input | 1 | A data write is issued this cycle |
| wr_data | input | 16 | Word driven by that write |
| flt_req | input | 1 | Fault request, sampled while idle |
| flt_addr | input | 32 | Faulting access address |
| flt_read | input | 1 | 1 = faulting access is a read |
| flt_byte | input | 1 | 1 = faulting access is byte-sized |
| flt_hib | input | 1 | High-byte attribute of the fault |
| flt_zup | input | 1 | Force the status word's upper byte to zero |
| flt_fetch | input | 1 | Fault happened on an instruction fetch |
| flt_fc | input | 3 | Function code of the faulting access |
| flt_wdata | input | 16 | Value a faulting write would have driven |
| flt_insn | input | 16 | Instruction word for the frame |
| flt_pc | input | 32 | Return PC for the frame |
| flt_sr | input | 16 | Status register for the frame |
| flt_vec | input | 8 | Exception vector number |
| sp_in | input | 32 | Supervisor stack pointer before the frame |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | 32 | Word write address |
| mem_wdata | output | 16 | Word write data |
| mem_rdy | input | 1 | Memory accepts the current word |
| sp_out | output | 32 | Lowered stack pointer |
| done | output | 1 | One-cycle pulse after the frame is written |

## Verification
The bench goes after the status-word corners. A fetch fault flagged as a read must still show bit 8 clear, and a design that trusted the read flag would set it. A zero-upper fault that also has the high-byte and byte attributes must lose them, and a design that masked too few bits would leak bit 9 or 10. The buffer slots are checked with traffic before the fault, with a write fault that must replace the written word and leave it latched, and with no traffic at all after reset. Frames are written under uneven memory-ready stalls and with a second request fired mid-frame. A sequencer that advanced without ready, moved its address during a stall, or restarted on the stray request would show the wrong word count, order or stack pointer.

// File: rtl/ffw_pkg.sv
// Package: shared types and frame slot positions of the fault frame writer.
// Assumes a 16-bit data word and a 32-bit address; slot numbers count words
// upward from the lowered stack pointer.
package ffw_pkg;

    localparam int WORD_W   = 16;
    localparam int ADR_W    = 32;

    // fixed slots of the lower frame area
    localparam int SLOT_SSW      = 0;
    localparam int SLOT_FADR_HI  = 1;
    localparam int SLOT_FADR_LO  = 2;
    localparam int SLOT_DOUT     = 4;
    localparam int SLOT_DIN      = 6;
    localparam int SLOT_INSN     = 8;
    localparam int HEAD_WORDS    = 10;   // slots 0..9, slot 9 is the version word
    localparam int TAIL_WORDS    = 4;    // SR, PC high, PC low, format word

    localparam logic [3:0] FRAME_FORMAT = 4'h8;

    // attributes of the faulting access
    typedef struct packed {
        logic       is_read;
        logic       is_byte;
        logic       high_byte;
        logic       zero_upper;
        logic       is_fetch;
        logic [2:0] fcode;
    } fault_attr_t;

endpackage

// File: rtl/ffw_buf_latch.sv
// Module: data buffer latch. Keeps the most recent word seen on a strobe.
// An override load takes priority over the normal strobe. q_live shows the
// value including this cycle's load, so a capture in the same cycle sees it.
// Assumes at most one override per cycle.
module ffw_buf_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    input  logic         ovr,
    input  logic [W-1:0] ovr_data,
    output logic [W-1:0] q_live
);

    logic [W-1:0] held_q;

    // choose the value that is current this cycle
    always_comb begin
        if (ovr)
            q_live = ovr_data;
        else if (ld)
            q_live = ld_data;
        else
            q_live = held_q;
    end

    // store the current value
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else
            held_q <= q_live;
    end

endmodule

// File: rtl/ffw_ssw_build.sv
// Module: special status word builder. Pure combinational.
// Assumes attr is already captured and steady for the whole frame.
module ffw_ssw_build
    import ffw_pkg::*;
(
    input  fault_attr_t         attr,
    output logic [WORD_W-1:0]   ssw
);

    // assemble the fields, then apply the upper-byte suppression
    always_comb begin
        ssw        = '0;
        ssw[2:0]   = attr.fcode;
        ssw[8]     = attr.is_read & ~attr.is_fetch;
        ssw[9]     = attr.is_byte;
        ssw[10]    = attr.high_byte;
        if (attr.zero_upper)
            ssw[15:8] = '0;
    end

endmodule

// File: rtl/ffw_frame_mux.sv
// Module: frame word selector. Maps a word index to the word stored there.
// Assumes idx < HEAD_WORDS + FILL_WORDS + TAIL_WORDS; any other slot is zero.
module ffw_frame_mux
    import ffw_pkg::*;
#(
    parameter int FILL_WORDS = 15,
    parameter int VEC_W      = 8,
    parameter int IDX_W      = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] ssw,
    input  logic [ADR_W-1:0]  fault_adr,
    input  logic [WORD_W-1:0] dout_buf,
    input  logic [WORD_W-1:0] din_buf,
    input  logic [WORD_W-1:0] insn,
    input  logic [WORD_W-1:0] sr,
    input  logic [ADR_W-1:0]  pc,
    input  logic [VEC_W-1:0]  vec,
    output logic [WORD_W-1:0] word
);

    localparam int SLOT_SR    = HEAD_WORDS + FILL_WORDS;
    localparam int SLOT_PC_HI = SLOT_SR + 1;
    localparam int SLOT_PC_LO = SLOT_SR + 2;
    localparam int SLOT_FMT   = SLOT_SR + 3;
    localparam int OFS_W      = WORD_W - 4;

    logic [OFS_W-1:0] vec_ofs;

    // vector offset is the vector number times four
    always_comb begin
        vec_ofs = OFS_W'({vec, 2'b00});
    end

    // pick the word for this slot, zero for all fill slots
    always_comb begin
        word = '0;
        if (int'(idx) == SLOT_SSW)
            word = ssw;
        else if (int'(idx) == SLOT_FADR_HI)
            word = fault_adr[ADR_W-1:WORD_W];
        else if (int'(idx) == SLOT_FADR_LO)
            word = fault_adr[WORD_W-1:0];
        else if (int'(idx) == SLOT_DOUT)
            word = dout_buf;
        else if (int'(idx) == SLOT_DIN)
            word = din_buf;
        else if (int'(idx) == SLOT_INSN)
            word = insn;
        else if (int'(idx) == SLOT_SR)
            word = sr;
        else if (int'(idx) == SLOT_PC_HI)
            word = pc[ADR_W-1:WORD_W];
        else if (int'(idx) == SLOT_PC_LO)
            word = pc[WORD_W-1:0];
        else if (int'(idx) == SLOT_FMT)
            word = {FRAME_FORMAT, vec_ofs};
    end

endmodule

// File: rtl/ffw_seq.sv
// Module: frame write sequencer. Walks the word index from 0 to WORDS-1,
// advancing only on a ready handshake, and pulses done after the last word.
// Assumes start is only honoured while idle; the caller gates it.
module ffw_seq #(
    parameter int WORDS = 29,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mem_rdy,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    // state: idle/busy, word index, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    idx  <= '0;
                end
            end else if (mem_rdy) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the index never moves without ready
    a_r8_idx_waits: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_rdy |=> $stable(idx) && busy);

endmodule

// File: rtl/fault_frame_writer.sv
// Module: address/bus-error exception frame writer (top).
// Tracks the last read and written data words, captures fault state on a
// request while idle, lowers the stack pointer by the frame size and writes
// the frame upward from the new stack pointer, one word per mem_rdy.
// Assumes the memory holds off mem_rdy as long as it needs; requests while
// busy are dropped.
module fault_frame_writer
    import ffw_pkg::*;
#(
    parameter int FILL_WORDS = 15,
    parameter int VEC_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [15:0]       rd_data,
    input  logic              wr_stb,
    input  logic [15:0]       wr_data,
    input  logic              flt_req,
    input  logic [31:0]       flt_addr,
    input  logic              flt_read,
    input  logic              flt_byte,
    input  logic              flt_hib,
    input  logic              flt_zup,
    input  logic              flt_fetch,
    input  logic [2:0]        flt_fc,
    input  logic [15:0]       flt_wdata,
    input  logic [15:0]       flt_insn,
    input  logic [31:0]       flt_pc,
    input  logic [15:0]       flt_sr,
    input  logic [VEC_W-1:0]  flt_vec,
    input  logic [31:0]       sp_in,
    output logic              mem_wr,
    output logic [31:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_rdy,
    output logic [31:0]       sp_out,
    output logic              done
);

    localparam int FRAME_WORDS = HEAD_WORDS + FILL_WORDS + TAIL_WORDS;
    localparam int FRAME_BYTES = 2 * FRAME_WORDS;
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    logic              busy;
    logic              accept;
    logic              write_fault;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] din_live;
    logic [WORD_W-1:0] dout_live;
    logic [WORD_W-1:0] ssw;
    fault_attr_t       attr_q;
    fault_attr_t       attr_in;
    logic [ADR_W-1:0]  fadr_q;
    logic [ADR_W-1:0]  pc_q;
    logic [WORD_W-1:0] din_q;
    logic [WORD_W-1:0] dout_q;
    logic [WORD_W-1:0] insn_q;
    logic [WORD_W-1:0] sr_q;
    logic [VEC_W-1:0]  vec_q;

    // request qualification and attribute bundling
    always_comb begin
        accept              = flt_req & ~busy;
        write_fault         = ~flt_read & ~flt_fetch;
        attr_in.is_read     = flt_read;
        attr_in.is_byte     = flt_byte;
        attr_in.high_byte   = flt_hib;
        attr_in.zero_upper  = flt_zup;
        attr_in.is_fetch    = flt_fetch;
        attr_in.fcode       = flt_fc;
    end

    // input buffer: last read word, prefetches included
    ffw_buf_latch #(.W(WORD_W)) u_rd_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (rd_stb),
        .ld_data  (rd_data),
        .ovr      (1'b0),
        .ovr_data ('0),
        .q_live   (din_live)
    );

    // output buffer: last written word, or the value a faulting write held
    ffw_buf_latch #(.W(WORD_W)) u_wr_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (wr_stb),
        .ld_data  (wr_data),
        .ovr      (accept & write_fault),
        .ovr_data (flt_wdata),
        .q_live   (dout_live)
    );

    // capture fault state and lower the stack pointer on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
            fadr_q <= '0;
            pc_q   <= '0;
            din_q  <= '0;
            dout_q <= '0;
            insn_q <= '0;
            sr_q   <= '0;
            vec_q  <= '0;
            sp_out <= '0;
        end else if (accept) begin
            attr_q <= attr_in;
            fadr_q <= flt_addr;
            pc_q   <= flt_pc;
            din_q  <= din_live;
            dout_q <= dout_live;
            insn_q <= flt_insn;
            sr_q   <= flt_sr;
            vec_q  <= flt_vec;
            sp_out <= sp_in - ADR_W'(FRAME_BYTES);
        end
    end

    ffw_ssw_build u_ssw (
        .attr (attr_q),
        .ssw  (ssw)
    );

    ffw_seq #(.WORDS(FRAME_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .mem_rdy (mem_rdy),
        .busy    (busy),
        .idx     (idx),
        .done    (done)
    );

    ffw_frame_mux #(.FILL_WORDS(FILL_WORDS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_mux (
        .idx       (idx),
        .ssw       (ssw),
        .fault_adr (fadr_q),
        .dout_buf  (dout_q),
        .din_buf   (din_q),
        .insn      (insn_q),
        .sr        (sr_q),
        .pc        (pc_q),
        .vec       (vec_q),
        .word      (mem_wdata)
    );

    // memory port: write while busy, address steps by two bytes per word
    always_comb begin
        mem_wr   = busy;
        mem_addr = sp_out + ADR_W'({idx, 1'b0});
    end

    // R8: address and data held while memory stalls
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_rdy |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    // R8: ascending order, one word per accepted handshake
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && mem_rdy && mem_addr != sp_out + ADR_W'(FRAME_BYTES - 2)
        |=> mem_addr == $past(mem_addr) + 32'd2);

    // R4: first word lands at the lowered stack pointer
    a_r4_sp_lowered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> sp_out == $past(sp_in) - ADR_W'(FRAME_BYTES) && mem_addr == sp_out);

    // R9: no write request in the done cycle
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_wr);

    // R10: a request while busy leaves the stack pointer alone
    a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && flt_req |=> $stable(sp_out));

endmodule

// File: tb/fault_frame_writer_tb_top.sv
module fault_frame_writer_tb_top;

    localparam int NWORDS = 29;
    localparam int NBYTES = 58;

    typedef struct packed {
        logic [31:0] addr;
        logic        rd;
        logic        by;
        logic        hb;
        logic        zu;
        logic        fe;
        logic [2:0]  fc;
        logic [15:0] wdata;
        logic [15:0] insn;
        logic [31:0] pc;
        logic [15:0] sr;
        logic [7:0]  vec;
        logic [31:0] sp;
        logic [3:0]  stall;
        logic        rd_en;
        logic [15:0] rdv;
        logic        wr_en;
        logic [15:0] wrv;
    } vec_t;

    // addr rd by hb zu fe fc wdata insn pc sr vec sp stall rd_en rdv wr_en wrv
    localparam vec_t VECS [5] = '{
        '{32'h0000_1233, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 16'h0000, 16'h3010, 32'h0001_0200, 16'h2700, 8'd3, 32'h0000_8000, 4'd0, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{32'h00AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 16'hBEEF, 16'h4E75, 32'h00FF_0010, 16'h2015, 8'd2, 32'h0001_0000, 4'd2, 1'b1, 16'h1111, 1'b1, 16'h2222},
        '{32'h1234_5679, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd6, 16'h0000, 16'h40E8, 32'h0000_4000, 16'h2004, 8'd3, 32'h0000_0400, 4'd1, 1'b1, 16'hA5C3, 1'b0, 16'h0000},
        '{32'h0000_0FFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 16'h5A5A, 16'hFFFF, 32'h0000_0FFF, 16'hA71F, 8'd2, 32'h0000_2000, 4'd3, 1'b0, 16'h0000, 1'b1, 16'h7E7E},
        '{32'hFFFF_FFFD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5, 16'hC0DE, 16'h0000, 32'hFFFF_FFFE, 16'h0000, 8'd255, 32'h0000_003A, 4'd0, 1'b1, 16'h0F0F, 1'b1, 16'h1234}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data = '0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flt_req = 1'b0;
    logic [31:0] flt_addr = '0;
    logic        flt_read = 1'b0;
    logic        flt_byte = 1'b0;
    logic        flt_hib = 1'b0;
    logic        flt_zup = 1'b0;
    logic        flt_fetch = 1'b0;
    logic [2:0]  flt_fc = '0;
    logic [15:0] flt_wdata = '0;
    logic [15:0] flt_insn = '0;
    logic [31:0] flt_pc = '0;
    logic [15:0] flt_sr = '0;
    logic [7:0]  flt_vec = '0;
    logic [31:0] sp_in = '0;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rdy = 1'b0;
    logic [31:0] sp_out;
    logic        done;

    fault_frame_writer dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_data(wr_data), .flt_req(flt_req), .flt_addr(flt_addr),
        .flt_read(flt_read), .flt_byte(flt_byte), .flt_hib(flt_hib), .flt_zup(flt_zup),
        .flt_fetch(flt_fetch), .flt_fc(flt_fc), .flt_wdata(flt_wdata), .flt_insn(flt_insn),
        .flt_pc(flt_pc), .flt_sr(flt_sr), .flt_vec(flt_vec), .sp_in(sp_in),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
        .sp_out(sp_out), .done(done)
    );

    always #5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    int          rdy_mode = 0;
    int          rdy_ctr = 0;
    int          wcnt = 0;
    int          order_err = 0;
    int          hold_err = 0;
    int          done_cnt = 0;
    bit          hold_pending = 0;
    logic [31:0] prev_addr = '0;
    logic [15:0] prev_data = '0;
    logic [31:0] exp_base = '0;
    logic [15:0] got [0:63];
    logic [15:0] last_rd = '0;
    logic [15:0] last_wr = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: ready pattern, capture of words, hold check
    always @(negedge clk) begin
        cycles++;
        if (rdy_mode == 0)
            mem_rdy = 1'b1;
        else begin
            rdy_ctr++;
            mem_rdy = ((rdy_ctr % (rdy_mode + 1)) == 0);
        end
        if (mem_wr) begin
            if (hold_pending && (mem_addr != prev_addr || mem_wdata != prev_data))
                hold_err++;
            if (mem_rdy) begin
                if (int'((mem_addr - exp_base) >> 1) != wcnt)
                    order_err++;
                if (((mem_addr - exp_base) >> 1) < 32'd64)
                    got[(mem_addr - exp_base) >> 1] = mem_wdata;
                wcnt++;
                hold_pending = 0;
            end else begin
                hold_pending = 1;
                prev_addr = mem_addr;
                prev_data = mem_wdata;
            end
        end
        if (done)
            done_cnt++;
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // R1/R2/R3 expectations from the requirement text
    function automatic logic [15:0] exp_ssw(input vec_t v);
        logic [15:0] s;
        s = '0;
        s[2:0] = v.fc;
        s[8]   = v.rd & ~v.fe;
        s[9]   = v.by;
        s[10]  = v.hb;
        if (v.zu) s[15:8] = '0;
        return s;
    endfunction

    // R5 layout
    function automatic logic [15:0] exp_word(input int k, input vec_t v,
                                             input logic [15:0] din, input logic [15:0] dout);
        case (k)
            0:  return exp_ssw(v);
            1:  return v.addr[31:16];
            2:  return v.addr[15:0];
            4:  return dout;
            6:  return din;
            8:  return v.insn;
            25: return v.sr;
            26: return v.pc[31:16];
            27: return v.pc[15:0];
            28: return {4'h8, 2'b00, v.vec, 2'b00};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic run_frame(input vec_t v, input string ssw_req, input bit stray_req);
        logic [15:0] e_din;
        logic [15:0] e_dout;
        int          bad;
        int          first_bad;
        int          waited;
        @(negedge clk);
        if (v.rd_en) begin rd_stb = 1'b1; rd_data = v.rdv; last_rd = v.rdv; end
        if (v.wr_en) begin wr_stb = 1'b1; wr_data = v.wrv; last_wr = v.wrv; end
        @(negedge clk);
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        e_din  = last_rd;
        e_dout = (!v.rd && !v.fe) ? v.wdata : last_wr;
        wcnt = 0; order_err = 0; hold_err = 0; done_cnt = 0; hold_pending = 0; rdy_ctr = 0;
        rdy_mode = int'(v.stall);
        exp_base = v.sp - NBYTES;
        for (int k = 0; k < 64; k++) got[k] = 16'hDEAD;
        flt_addr = v.addr; flt_read = v.rd; flt_byte = v.by; flt_hib = v.hb;
        flt_zup = v.zu; flt_fetch = v.fe; flt_fc = v.fc; flt_wdata = v.wdata;
        flt_insn = v.insn; flt_pc = v.pc; flt_sr = v.sr; flt_vec = v.vec; sp_in = v.sp;
        flt_req = 1'b1;
        @(negedge clk);
        flt_req = 1'b0;
        if (stray_req) begin
            repeat (4) @(negedge clk);
            sp_in = v.sp + 32'h100;
            flt_addr = 32'h5555_5555;
            flt_insn = 16'h9999;
            flt_req = 1'b1;
            @(negedge clk);
            flt_req = 1'b0;
            check(sp_out == exp_base, "R10 sp_out during stray request", sp_out, exp_base);
        end
        waited = 0;
        while (done_cnt == 0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 2000, "R9 done reached", waited, 2000);
        check(!mem_wr, "R9 mem_wr low in done cycle", mem_wr, 0);
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R9 done pulse length", done_cnt, 1);
        check(wcnt == NWORDS, "R8 word count", wcnt, NWORDS);
        check(order_err == 0, "R8 ascending order", order_err, 0);
        check(hold_err == 0, "R8 hold during stall", hold_err, 0);
        check(sp_out == v.sp - NBYTES, "R4 lowered stack pointer", sp_out, v.sp - NBYTES);
        check(got[0] == exp_ssw(v), ssw_req, got[0], exp_ssw(v));
        check(got[6] == e_din, "R6 input buffer slot", got[6], e_din);
        check(got[4] == e_dout, "R7 output buffer slot", got[4], e_dout);
        bad = 0;
        first_bad = -1;
        for (int k = 0; k < NWORDS; k++)
            if (got[k] !== exp_word(k, v, e_din, e_dout)) begin
                bad++;
                if (first_bad < 0) first_bad = k;
            end
        check(bad == 0, "R5 frame layout (first bad word index as actual)", first_bad, -1);
        if (!v.rd && !v.fe) last_wr = v.wdata;
        rdy_mode = 0;
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check(mem_wr == 1'b0, "R11 mem_wr in reset", mem_wr, 0);
        check(done == 1'b0, "R11 done in reset", done, 0);
        check(sp_out == 32'h0, "R11 sp_out in reset", sp_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table; the first entry runs with no prior traffic (R11 latch clear)
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: run_frame(VECS[i], "R1 R11 status word read", 1'b0);
                1: run_frame(VECS[i], "R1 R7 status word byte write", 1'b0);
                2: run_frame(VECS[i], "R3 zero-upper status word", 1'b0);
                3: run_frame(VECS[i], "R2 fetch fault status word", 1'b0);
                default: run_frame(VECS[i], "R3 zero-upper write status word", 1'b0);
            endcase
        end

        // R7: a write-fault value stays in the write latch for the next frame
        begin
            vec_t v;
            v = VECS[2];
            v.rd_en = 1'b0;
            v.wr_en = 1'b0;
            v.sp = 32'h0000_6000;
            run_frame(v, "R3 repeat status word", 1'b0);
            check(got[4] == 16'hC0DE, "R7 override value retained", got[4], 16'hC0DE);
        end

        // R10: stray request in the middle of a stalled frame
        begin
            vec_t v;
            v = VECS[1];
            v.stall = 4'd3;
            run_frame(v, "R1 status word under stray request", 1'b1);
            check(got[8] == v.insn, "R10 frame unaltered by stray request", got[8], v.insn);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule